// File: doc/BRIEF.md
# Asynchronous byte-lane static RAM model

A synthesizable functional model of a 16-bit asynchronous static RAM with two byte lanes, for use in place of the external memory in a chip-level simulation or an FPGA prototype. Access is gated by two chip selects of opposite polarity and by a lower and an upper lane enable. Write enable and output enable then pick write, read or output-disable. The bidirectional data bus is split into an input vector, an output vector and a per-bit drive enable. A bit whose enable is 0 is high-impedance.

An 8-bit mode is selected by a low byte-mode input. In that mode the top data pin is taken as an extra address bit below bit 0: 0 picks the low byte of the word and 1 picks the high byte. Data then moves on bits 0–7 only. The array depth is set by the address-width parameter. A fast free-running simulation clock samples the asynchronous controls. A write is held open while its gating conditions hold, and it is committed on the clock edge where that window closes.

Top module: `sram_model`

## Requirements
- R1: All 16 drive enables are 0 when the active-low select is high, when the active-high select is low, or when both lane enables are high.
- R2: In 16-bit mode a write updates bits 7:0 only when the lower enable is low and bits 15:8 only when the upper enable is low. A lane that is not enabled keeps its old contents.
- R3: In 16-bit mode a read (selected, write enable high, output enable low) drives bits 7:0 when the lower enable is low and bits 15:8 when the upper enable is low, each with the stored data. The other lane stays high-impedance.
- R4: Selected with both write enable and output enable high, no bit is driven.
- R5: A write window lasts while both selects are active, write enable is low and at least one lane enable is low. The value stored is the data and address from the last clock cycle of that window. Ending the window through any one of these conditions commits it, and the new data is readable in the first cycle after the window closes.
- R6: In 8-bit mode (byte-mode input low, both lane enables low), data bit 15 is address bit minus-one. 0 selects bits 7:0 of the word and 1 selects bits 15:8. A write stores data bits 7:0 into that byte only.
- R7: An 8-bit mode read drives bits 7:0 with the selected byte. Bits 8–15 are never driven in 8-bit mode.
- R8: When both selects are active in 8-bit mode with either lane enable high, err_o is 1, no bit is driven, and no write takes place.
- R9: No bit is driven while write enable is low.
- R10: Asserting rst_ni low discards a write window that is open. Memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| lb_n_i | input | 1 | Lower lane (bits 7:0) enable, active low |
| ub_n_i | input | 1 | Upper lane (bits 15:8) enable, active low |
| byte_n_i | input | 1 | Low selects 8-bit mode |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 16 | Data bus, inbound value |
| dq_o | output | 16 | Data bus, outbound value |
| dq_oe_o | output | 16 | Per-bit drive enable for dq_o |
| err_o | output | 1 | 8-bit mode entered with a lane enable high |

## Verification
A wrong lane mask or a wrong minus-one address bit leaves corrupted bytes in the array. These show on the next read of that word, which may come many operations later. The bench therefore keeps a reference image of the whole array and compares every read against it. A commit at the wrong cycle, or from stale capture registers, shows on the read in the first cycle after the window closes. That read is made immediately. Drive-enable errors show in the same cycle as the controls that cause them, so they are checked during writes, deselects and output-disable as well as during reads.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic sel;     // chip active, lane(s) enabled, no mode error
    logic wr;
    logic rd;
    logic byte_m;
    logic err;
  } acc_t;
endpackage

// File: rtl/sram_acc_dec.sv
module sram_acc_dec
  import sram_model_pkg::*;
(
  input  logic             cs_n_i,
  input  logic             cs_i,
  input  logic             we_n_i,
  input  logic             oe_n_i,
  input  logic             lb_n_i,
  input  logic             ub_n_i,
  input  logic             byte_n_i,
  input  logic             am1_i,
  output acc_t             acc_o,
  output logic [LANES-1:0] be_o
);
  logic chip, any_lane;

  always_comb begin
    chip          = !cs_n_i && cs_i;
    any_lane      = !lb_n_i || !ub_n_i;
    acc_o.byte_m  = !byte_n_i;
    acc_o.err     = chip && acc_o.byte_m && (lb_n_i || ub_n_i);
    acc_o.sel     = chip && any_lane && !acc_o.err;
    acc_o.wr      = acc_o.sel && !we_n_i;
    acc_o.rd      = acc_o.sel && we_n_i && !oe_n_i;
    if (acc_o.byte_m) be_o = am1_i ? 2'b10 : 2'b01;
    else              be_o = {!ub_n_i, !lb_n_i};
  end
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  be_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  be_o
);
  logic act_q;

  // track latest values while the window is open; commit when it closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      be_o   <= '0;
    end else begin
      act_q <= wr_i;
      if (wr_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
        be_o   <= be_i;
      end
    end
  end

  assign commit_o = act_q && !wr_i;

  a_r5_commit_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_i));
  a_r5_commit_has_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (be_o != '0));
endmodule

// File: rtl/sram_store.sv
module sram_store
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[g]) mem_q[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/sram_model.sv
module sram_model
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              cs_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic              lb_n_i,
  input  logic              ub_n_i,
  input  logic              byte_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe_o,
  output logic              err_o
);
  acc_t              acc;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wdata, rdata;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic [LANES-1:0]  c_be;
  logic              am1;

  assign am1 = dq_i[DATA_W-1];

  sram_acc_dec u_dec (
    .cs_n_i, .cs_i, .we_n_i, .oe_n_i, .lb_n_i, .ub_n_i, .byte_n_i,
    .am1_i (am1),
    .acc_o (acc),
    .be_o  (be)
  );

  // 8-bit mode: replicate the byte so either lane can take it
  assign wdata = acc.byte_m ? {LANES{dq_i[LANE_W-1:0]}} : dq_i;

  sram_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .wr_i     (acc.wr),
    .addr_i   (addr_i),
    .data_i   (wdata),
    .be_i     (be),
    .commit_o (commit),
    .addr_o   (c_addr),
    .data_o   (c_data),
    .be_o     (c_be)
  );

  sram_store #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i,
    .we_i    (commit),
    .waddr_i (c_addr),
    .wdata_i (c_data),
    .wbe_i   (c_be),
    .raddr_i (addr_i),
    .rdata_o (rdata)
  );

  always_comb begin
    dq_o    = rdata;
    dq_oe_o = '0;
    if (acc.byte_m) begin
      dq_o[LANE_W-1:0] = am1 ? rdata[DATA_W-1 -: LANE_W] : rdata[LANE_W-1:0];
      if (acc.rd) dq_oe_o[LANE_W-1:0] = '1;
    end else if (acc.rd) begin
      dq_oe_o = {{LANE_W{be[1]}}, {LANE_W{be[0]}}};
    end
  end

  assign err_o = acc.err;

  a_r1_deselect_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i || !cs_i || (lb_n_i && ub_n_i)) |-> (dq_oe_o == '0));
  a_r4_out_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_n_i && oe_n_i) |-> (dq_oe_o == '0));
  a_r9_no_drive_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> (dq_oe_o == '0));
  a_r7_byte_upper_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_n_i |-> (dq_oe_o[15:8] == '0));
  a_r8_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (dq_oe_o == '0 && !acc.wr));
endmodule

// File: tb/sram_model_test.sv
module sram_model_test;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 0, rst_ni = 0;
  logic          cs_n_i, cs_i, we_n_i, oe_n_i, lb_n_i, ub_n_i, byte_n_i;
  logic [AW-1:0] addr_i;
  logic [15:0]   dq_i, dq_o, dq_oe_o;
  logic          err_o;

  logic [15:0] ref_mem [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  sram_model #(.ADDR_W(AW)) uut (.*);

  function automatic logic [7:0] exp_byte(int a, bit am1);
    return am1 ? ref_mem[a][15:8] : ref_mem[a][7:0];
  endfunction

  function automatic logic [15:0] exp_word_oe(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n_i = 1; cs_i = 1; we_n_i = 1; oe_n_i = 1;
    lb_n_i = 0; ub_n_i = 0; byte_n_i = 1; dq_i = '0; addr_i = '0;
  endtask

  // be[0]=lower lane, be[1]=upper lane; kind selects how the window ends
  task automatic word_write(int a, logic [15:0] d, logic [1:0] be, int kind);
    @(negedge clk_i);
    cs_n_i = 0; cs_i = 1; oe_n_i = 0; byte_n_i = 1;
    lb_n_i = !be[0]; ub_n_i = !be[1]; addr_i = AW'(a); we_n_i = 0; dq_i = ~d;
    #1 chk("R9 no drive while writing", {16'h0, dq_oe_o}, 32'h0);
    @(negedge clk_i); dq_i = d;
    @(negedge clk_i);
    case (kind)
      0: we_n_i = 1;
      1: cs_n_i = 1;
      2: cs_i = 0;
      default: begin lb_n_i = 1; ub_n_i = 1; end
    endcase
    if (be[0]) ref_mem[a][7:0]  = d[7:0];
    if (be[1]) ref_mem[a][15:8] = d[15:8];
    @(negedge clk_i); idle();
  endtask

  task automatic byte_write(int a, bit am1, logic [7:0] b);
    @(negedge clk_i);
    cs_n_i = 0; cs_i = 1; oe_n_i = 1; byte_n_i = 0; lb_n_i = 0; ub_n_i = 0;
    addr_i = AW'(a); we_n_i = 0; dq_i = {am1, 7'h55, ~b};
    @(negedge clk_i); dq_i = {am1, 7'h2a, b};
    @(negedge clk_i); we_n_i = 1;
    if (am1) ref_mem[a][15:8] = b; else ref_mem[a][7:0] = b;
    @(negedge clk_i); idle();
  endtask

  task automatic word_read(string req, int a, logic [1:0] be);
    logic [15:0] eoe;
    @(negedge clk_i);
    cs_n_i = 0; cs_i = 1; we_n_i = 1; oe_n_i = 0; byte_n_i = 1;
    lb_n_i = !be[0]; ub_n_i = !be[1]; addr_i = AW'(a);
    eoe = exp_word_oe(be);
    #1;
    chk({req, " oe"}, {16'h0, dq_oe_o}, {16'h0, eoe});
    chk({req, " data"}, {16'h0, dq_o & eoe}, {16'h0, ref_mem[a] & eoe});
  endtask

  task automatic byte_read(int a, bit am1);
    @(negedge clk_i);
    cs_n_i = 0; cs_i = 1; we_n_i = 1; oe_n_i = 0; byte_n_i = 0;
    lb_n_i = 0; ub_n_i = 0; addr_i = AW'(a); dq_i = {am1, 15'h0};
    #1;
    chk("R7 byte oe", {16'h0, dq_oe_o}, 32'h00ff);
    chk("R6 byte data", {24'h0, dq_o[7:0]}, {24'h0, exp_byte(a, am1)});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1 reset idle oe", {16'h0, dq_oe_o}, 32'h0);
    chk("R8 reset idle err", {31'h0, err_o}, 32'h0);

    // fill, cycling through all four ways to close a write (R5, R2)
    for (int a = 0; a < DEPTH; a++)
      word_write(a, 16'(a * 16'h0101) ^ 16'h5a3c, 2'b11, a % 4);
    for (int a = 0; a < DEPTH; a++) word_read("R5 fill readback", a, 2'b11);

    // R5: read in the first cycle after the window closes
    word_write(7, 16'hbeef, 2'b11, 2);
    word_read("R5 immediate", 7, 2'b11);
    // R2: single lane write keeps other lane
    word_write(9, 16'h1234, 2'b01, 0);
    word_read("R2 lower only", 9, 2'b11);
    word_write(9, 16'hab00, 2'b10, 1);
    word_read("R2 upper only", 9, 2'b11);
    // R3: partial lane reads
    word_read("R3 lower lane", 9, 2'b01);
    word_read("R3 upper lane", 9, 2'b10);

    // R1 deselects, R4 output disable
    @(negedge clk_i);
    cs_n_i = 1; cs_i = 1; we_n_i = 1; oe_n_i = 0; lb_n_i = 0; ub_n_i = 0; byte_n_i = 1;
    #1 chk("R1 cs_n high", {16'h0, dq_oe_o}, 32'h0);
    cs_n_i = 0; cs_i = 0;
    #1 chk("R1 cs low", {16'h0, dq_oe_o}, 32'h0);
    cs_i = 1; lb_n_i = 1; ub_n_i = 1;
    #1 chk("R1 lanes off", {16'h0, dq_oe_o}, 32'h0);
    lb_n_i = 0; ub_n_i = 0; oe_n_i = 1;
    #1 chk("R4 output disable", {16'h0, dq_oe_o}, 32'h0);

    // R8: byte mode with one lane enable high
    @(negedge clk_i);
    cs_n_i = 0; cs_i = 1; byte_n_i = 0; lb_n_i = 1; ub_n_i = 0;
    oe_n_i = 1; we_n_i = 0; addr_i = AW'(11); dq_i = 16'h80a5;
    #1 chk("R8 err flag", {31'h0, err_o}, 32'h1);
    @(negedge clk_i); we_n_i = 1; oe_n_i = 0;
    #1 chk("R8 no drive", {16'h0, dq_oe_o}, 32'h0);
    @(negedge clk_i); idle();
    word_read("R8 no write", 11, 2'b11);

    // R10: reset discards open window
    @(negedge clk_i);
    cs_n_i = 0; cs_i = 1; byte_n_i = 1; lb_n_i = 0; ub_n_i = 0;
    addr_i = AW'(13); we_n_i = 0; dq_i = 16'hdead;
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); we_n_i = 1; rst_ni = 1;
    @(negedge clk_i); idle();
    word_read("R10 reset discards", 13, 2'b11);

    // R6/R7 directed byte accesses
    byte_write(20, 1'b1, 8'hc3);
    byte_write(20, 1'b0, 8'h3c);
    byte_read(20, 1'b1);
    byte_read(20, 1'b0);
    word_read("R6 byte into word", 20, 2'b11);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom % DEPTH);
      case ($urandom % 4)
        0: word_write(a, 16'($urandom), 2'(1 + $urandom % 3), int'($urandom % 4));
        1: word_read("R3 random", a, 2'(1 + $urandom % 3));
        2: byte_write(a, 1'($urandom), 8'($urandom));
        default: byte_read(a, 1'($urandom));
      endcase
    end

    done = 1;
    finish_run();
  end
endmodule